// File: doc/BRIEF.md
# Transmit Frame Buffer with Length-Driven Send Decision

This block gathers one outgoing Ethernet frame from 32-bit register writes into a byte buffer and then plays it out as a byte stream. Software first writes a word whose low half holds the payload length, then the header and payload words. The block works out by itself when enough bytes have arrived to make up the frame. Once that point is reached and a programmable fill level has also been crossed, it starts sending. Software can also force a send at any time with a transmit request.

The outgoing stream starts two bytes into the buffer, so the length field is skipped. It carries the 14 header bytes plus the payload. With padding on, it is extended with zero bytes to the 60-byte minimum. When the last byte has been accepted, the buffer is emptied and a one-cycle empty event is raised. A length word that is too large is rejected with a one-cycle error event. Software clears that condition with an acknowledge write, which also empties the buffer.

Top module: `tx_frame_fifo`

## Requirements
- R1: Each data write is stored as four bytes at the current fill offset, bits 7:0 first and bits 31:24 last. The stream sends buffer bytes in offset order starting at offset 2. A data write has select code 0.
- R2: While the buffer is empty, bits 15:0 of a data write are taken as the payload length. A length above 2032 discards the word, leaves the buffer empty and pulses `tx_err_o` for one cycle, in the cycle after the write.
- R3: A data write that would take the fill count past 2048 bytes is dropped and changes no stored byte.
- R4: The frame counts as complete when the fill count is at least length+16. Add 4 when auto-CRC (control bit 1) is 0. The total is capped at 2048.
- R5: The fill-level code (select 2, 6 bits) is reset to 0x3F, which disables automatic sending. For any other value v, the level is reached when the fill count is at least 32·v+4.
- R6: After a data write, sending starts automatically if the fill level is reached and the frame is complete. `tx_valid_o` rises in the following cycle.
- R7: A write with select code 3 and bit 0 set starts sending at once, whatever the fill count. It uses the length last captured.
- R8: The stream carries length+14 bytes. When padding (control bit 0, select 1) is 1 and that count is below 60, zero bytes follow until 60 bytes have been sent. Buffer bytes beyond the frame never appear.
- R9: The byte count of a stream never exceeds 2046. A 2032-byte payload yields exactly 2046 bytes.
- R10: When the last byte is accepted, the fill count returns to 0 and `tx_empty_o` pulses for one cycle.
- R11: A write with select code 4 and bit 0 set acknowledges the error and empties the buffer. The next data word is then taken as a length.
- R12: Data writes made while a frame is being streamed are ignored.
- R13: `tx_last_o` marks the final byte. While `tx_valid_o` is high and `tx_ready_i` is low, data and last hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 data, 1 control, 2 fill level, 3 transmit request, 4 error acknowledge |
| wr_data_i | input | 32 | Write data |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| tx_err_o | output | 1 | One-cycle pulse: length word rejected |
| tx_empty_o | output | 1 | One-cycle pulse: frame sent, buffer empty |

## Verification
The bench goes after the exact write at which a frame becomes complete. With auto-CRC on and off, it checks that nothing starts one word early. A design that dropped the extra 4 bytes, or left out the 2048 cap, would start too soon or never start the longest frame.

Padding is tested with stale bytes sitting in the buffer past the frame end, so a design that sends buffer contents instead of zeros miscompares. The bench also checks the 2046-byte frame, a length of 2033, writes past a full buffer, writes made while a stalled stream is in flight, and an acknowledge of a half-written frame. A design that wrapped the write pointer, accepted writes while busy or kept a stale fill count would shift or corrupt a later frame, and the byte scoreboard would catch it.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  typedef enum logic [2:0] {
    WSEL_DATA = 3'd0,
    WSEL_CTRL = 3'd1,
    WSEL_THR  = 3'd2,
    WSEL_TREQ = 3'd3,
    WSEL_ACK  = 3'd4
  } wsel_e;

  localparam int HDR_BYTES   = 14;
  localparam int LEN_BYTES   = 2;
  localparam int TAIL_BYTES  = 4;
  localparam int MIN_FRAME   = 60;
endpackage

// File: rtl/tfifo_buf.sv
module tfifo_buf #(
  parameter int BUF_BYTES = 2048,
  localparam int FILL_W = $clog2(BUF_BYTES) + 1,
  localparam int OFF_W  = $clog2(BUF_BYTES),
  localparam int WORDS  = BUF_BYTES / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [31:0]       data_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [FILL_W-1:0] fill_o,
  output logic [15:0]       len_o,
  output logic              room_o,
  output logic [7:0]        rd_byte_o
);
  localparam logic [FILL_W-1:0] ROOM_LIM = FILL_W'(BUF_BYTES - 4);

  logic [31:0]       mem_q [WORDS];
  logic [FILL_W-1:0] fill_q;
  logic [15:0]       len_q;
  logic [31:0]       rd_word;
  logic              wr_ok;

  assign room_o = (fill_q <= ROOM_LIM);
  assign wr_ok  = push_i && room_o;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[fill_q[OFF_W-1:2]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      len_q  <= '0;
    end else begin
      if (push_i && fill_q == '0) len_q <= data_i[15:0];
      if (clr_i)      fill_q <= '0;
      else if (wr_ok) fill_q <= fill_q + FILL_W'(4);
    end
  end

  assign rd_word   = mem_q[rd_off_i[OFF_W-1:2]];
  assign rd_byte_o = rd_word[{rd_off_i[1:0], 3'b000} +: 8];
  assign fill_o    = fill_q;
  assign len_o     = len_q;
endmodule

// File: rtl/tfifo_decide.sv
module tfifo_decide
  import tfifo_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 2032,
  parameter int THR_W     = 6,
  localparam int FILL_W   = $clog2(BUF_BYTES) + 1
) (
  input  logic              data_wr_i,
  input  logic              treq_i,
  input  logic              busy_i,
  input  logic [15:0]       len_field_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [15:0]       len_i,
  input  logic              room_i,
  input  logic              crc_en_i,
  input  logic              pad_en_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              push_o,
  output logic              err_o,
  output logic              start_o,
  output logic [FILL_W-1:0] cnt_o,
  output logic [FILL_W-1:0] lim_o
);
  localparam logic [16:0]       BUF_L    = 17'(BUF_BYTES);
  localparam logic [16:0]       OUT_MAX  = 17'(BUF_BYTES - LEN_BYTES);
  localparam logic [16:0]       PAD_MIN  = 17'(MIN_FRAME);
  localparam logic [THR_W-1:0]  THR_OFF  = '1;

  logic              first, too_long, reached, complete, auto_go;
  logic [15:0]       len_eff;
  logic [16:0]       need, base, padded;
  logic [FILL_W-1:0] fill_nx, need_cap, thr_lvl;

  assign first    = (fill_i == '0);
  assign too_long = data_wr_i && !busy_i && first && (len_field_i > 16'(MAX_LEN));
  assign push_o   = data_wr_i && !busy_i && !too_long;
  assign err_o    = too_long;

  assign fill_nx  = (push_o && room_i) ? fill_i + FILL_W'(4) : fill_i;
  assign len_eff  = (push_o && first) ? len_field_i : len_i;

  // complete: length word + header + payload (+ tail when CRC is not automatic)
  assign need     = {1'b0, len_eff} + 17'(LEN_BYTES + HDR_BYTES)
                    + (crc_en_i ? 17'd0 : 17'(TAIL_BYTES));
  assign need_cap = (need > BUF_L) ? FILL_W'(BUF_BYTES) : need[FILL_W-1:0];
  assign complete = (fill_nx >= need_cap);

  assign thr_lvl  = FILL_W'({thr_i, 5'b00000}) + FILL_W'(4);
  assign reached  = (thr_i != THR_OFF) && (fill_nx >= thr_lvl);

  assign auto_go  = push_o && reached && complete;
  assign start_o  = (auto_go || treq_i) && !busy_i;

  assign base     = {1'b0, len_eff} + 17'(HDR_BYTES);
  assign padded   = (pad_en_i && base < PAD_MIN) ? PAD_MIN : base;
  assign cnt_o    = (padded > OUT_MAX) ? OUT_MAX[FILL_W-1:0] : padded[FILL_W-1:0];
  assign lim_o    = (base > OUT_MAX) ? OUT_MAX[FILL_W-1:0] : base[FILL_W-1:0];
endmodule

// File: rtl/tfifo_tx.sv
module tfifo_tx
  import tfifo_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int FILL_W = $clog2(BUF_BYTES) + 1,
  localparam int OFF_W  = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FILL_W-1:0] cnt_i,
  input  logic [FILL_W-1:0] lim_i,
  input  logic [7:0]        rd_byte_i,
  input  logic              ready_i,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic [7:0]        data_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              done_o,
  output logic              busy_o
);
  logic              busy_q;
  logic [FILL_W-1:0] idx_q, cnt_q, lim_q, off_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= cnt_i;
      lim_q  <= lim_i;
    end else if (busy_q && ready_i) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + FILL_W'(1);
    end
  end

  assign off_full = idx_q + FILL_W'(LEN_BYTES);
  assign rd_off_o = off_full[OFF_W-1:0];
  assign valid_o  = busy_q;
  assign last_o   = busy_q && (idx_q == cnt_q - FILL_W'(1));
  // bytes past the frame proper are pad zeros
  assign data_o   = (idx_q < lim_q) ? rd_byte_i : 8'h00;
  assign done_o   = busy_q && ready_i && last_o;
  assign busy_o   = busy_q;
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tfifo_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 2032,
  parameter int THR_W     = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        tx_err_o,
  output logic        tx_empty_o
);
  localparam int FILL_W = $clog2(BUF_BYTES) + 1;
  localparam int OFF_W  = $clog2(BUF_BYTES);

  wsel_e             sel;
  logic              pad_q, crc_q, err_q, empty_q;
  logic [THR_W-1:0]  thr_q;
  logic              data_wr, treq, ack, clr;
  logic              push, err, start, done, busy, room;
  logic [FILL_W-1:0] fill_w, cnt, lim;
  logic [15:0]       len;
  logic [OFF_W-1:0]  rd_off;
  logic [7:0]        rd_byte;

  assign sel     = wsel_e'(wr_sel_i);
  assign data_wr = wr_en_i && (sel == WSEL_DATA);
  assign treq    = wr_en_i && (sel == WSEL_TREQ) && wr_data_i[0];
  assign ack     = wr_en_i && (sel == WSEL_ACK) && wr_data_i[0];
  assign clr     = done || ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_q   <= 1'b0;
      crc_q   <= 1'b0;
      thr_q   <= '1;
      err_q   <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      if (wr_en_i && sel == WSEL_CTRL) begin
        pad_q <= wr_data_i[0];
        crc_q <= wr_data_i[1];
      end
      if (wr_en_i && sel == WSEL_THR) thr_q <= wr_data_i[THR_W-1:0];
      err_q   <= err;
      empty_q <= done;
    end
  end

  tfifo_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .data_i   (wr_data_i),
    .clr_i    (clr),
    .rd_off_i (rd_off),
    .fill_o   (fill_w),
    .len_o    (len),
    .room_o   (room),
    .rd_byte_o(rd_byte)
  );

  tfifo_decide #(.BUF_BYTES(BUF_BYTES), .MAX_LEN(MAX_LEN), .THR_W(THR_W)) u_decide (
    .data_wr_i  (data_wr),
    .treq_i     (treq),
    .busy_i     (busy),
    .len_field_i(wr_data_i[15:0]),
    .fill_i     (fill_w),
    .len_i      (len),
    .room_i     (room),
    .crc_en_i   (crc_q),
    .pad_en_i   (pad_q),
    .thr_i      (thr_q),
    .push_o     (push),
    .err_o      (err),
    .start_o    (start),
    .cnt_o      (cnt),
    .lim_o      (lim)
  );

  tfifo_tx #(.BUF_BYTES(BUF_BYTES)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cnt_i    (cnt),
    .lim_i    (lim),
    .rd_byte_i(rd_byte),
    .ready_i  (tx_ready_i),
    .rd_off_o (rd_off),
    .data_o   (tx_data_o),
    .valid_o  (tx_valid_o),
    .last_o   (tx_last_o),
    .done_o   (done),
    .busy_o   (busy)
  );

  assign tx_err_o   = err_q;
  assign tx_empty_o = empty_q;
endmodule

// File: rtl/tx_frame_fifo_chk.sv
module tx_frame_fifo_chk #(
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 2032,
  localparam int FILL_W   = $clog2(BUF_BYTES) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        wr_sel_i,
  input logic [31:0]       wr_data_i,
  input logic [7:0]        tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_last_o,
  input logic              tx_ready_i,
  input logic              tx_err_o,
  input logic              tx_empty_o,
  input logic [FILL_W-1:0] fill_i
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i <= FILL_W'(BUF_BYTES)) && (fill_i[1:0] == 2'b00));

  assert_len_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> $past(wr_en_i && wr_sel_i == 3'd0 && fill_i == '0 && !tx_valid_o
                       && wr_data_i[15:0] > 16'(MAX_LEN)));

  assert_empty_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> $past(tx_valid_o && tx_ready_i && tx_last_o));

  assert_fill_cleared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && tx_last_o) |=> (fill_i == '0));

  assert_busy_write_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !(tx_ready_i && tx_last_o) && wr_en_i && wr_sel_i == 3'd0)
    |=> (fill_i == $past(fill_i)));

  assert_stall_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));
endmodule

bind tx_frame_fifo tx_frame_fifo_chk #(.BUF_BYTES(BUF_BYTES), .MAX_LEN(MAX_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .tx_data_o (tx_data_o),
  .tx_valid_o(tx_valid_o),
  .tx_last_o (tx_last_o),
  .tx_ready_i(tx_ready_i),
  .tx_err_o  (tx_err_o),
  .tx_empty_o(tx_empty_o),
  .fill_i    (fill_w)
);

// File: tb/tx_frame_fifo_bench.sv
module tx_frame_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUF  = 2048;
  localparam int MAXL = 2032;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_err, tx_empty;
  logic        tx_ready = 1'b0;

  tx_frame_fifo u_tx_frame_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready),
    .tx_err_o(tx_err), .tx_empty_o(tx_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [8:0] exp_q[$];
  logic [7:0] shadow [BUF];
  int m_fill = 0, m_len = 0, thr_m = 63;
  bit pad_m = 0, crc_m = 0;
  int n_chk = 0, n_bad = 0;
  int err_seen = 0, empty_seen = 0, exp_err = 0, exp_empty = 0;
  bit hold_ready = 0, finished = 0;
  logic [7:0] lfsr = 8'h5a;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: drives ready, compares accepted bytes against the scoreboard
  always begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = hold_ready ? 1'b0 : (lfsr[0] | lfsr[1]);
    if (rst_n) begin
      if (tx_err)   err_seen++;
      if (tx_empty) empty_seen++;
    end
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, int'(tx_data), -1);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({tx_last, tx_data} == e, cur_req, int'({tx_last, tx_data}), int'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected stream from the buffer model: offset 2 onward, zero pad (R1, R8, R9)
  task automatic push_frame();
    int base, cnt;
    base = m_len + 14;
    cnt = (pad_m && base < 60) ? 60 : base;
    if (cnt > BUF - 2) cnt = BUF - 2;
    for (int k = 0; k < cnt; k++)
      exp_q.push_back({(k == cnt - 1), (k < base) ? shadow[k + 2] : 8'h00});
    m_fill = 0;
    exp_empty++;
  endtask

  task automatic data_wr(input logic [31:0] w);
    int need;
    if (m_fill == 0) begin
      if (int'(w[15:0]) > MAXL) begin
        exp_err++;
        wr(3'd0, w);
        return;
      end
      m_len = int'(w[15:0]);
    end
    if (m_fill + 4 <= BUF) begin
      for (int b = 0; b < 4; b++) shadow[m_fill + b] = w[8*b +: 8];
      m_fill += 4;
    end
    need = m_len + 16 + (crc_m ? 0 : 4);
    if (need > BUF) need = BUF;
    if (thr_m != 63 && m_fill >= 32 * thr_m + 4 && m_fill >= need) push_frame();
    wr(3'd0, w);
  endtask

  task automatic set_ctrl(input bit pad, input bit crc);
    pad_m = pad; crc_m = crc;
    wr(3'd1, {30'd0, crc, pad});
  endtask

  task automatic set_thr(input int t);
    thr_m = t;
    wr(3'd2, 32'(t));
  endtask

  task automatic treq();
    push_frame();
    wr(3'd3, 32'd1);
  endtask

  function automatic logic [31:0] word_of(input int len, input int seed, input int w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      int off;
      off = 4 * w + b;
      if (off == 0)      r[8*b +: 8] = len[7:0];
      else if (off == 1) r[8*b +: 8] = len[15:8];
      else               r[8*b +: 8] = 8'((off * 13 + seed) & 255);
    end
    return r;
  endfunction

  task automatic put_words(input int len, input int seed, input int from, input int to);
    for (int w = from; w < to; w++) data_wr(word_of(len, seed, w));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid == 1'b0, "R5", int'(tx_valid), 0);
    check(tx_err == 1'b0 && tx_empty == 1'b0, "R10", int'({tx_err, tx_empty}), 0);

    // R5 reset level disabled, R7 request, R1 byte order
    cur_req = "R7";
    set_ctrl(0, 1);
    put_words(20, 3, 0, 9);
    check(tx_valid == 1'b0, "R5", int'(tx_valid), 0);
    treq();
    drain();

    // R4 completeness, R6 auto start, R8 padding past stale bytes
    cur_req = "R8";
    set_ctrl(1, 1);
    set_thr(0);
    put_words(10, 41, 0, 6);
    check(tx_valid == 1'b0, "R4", int'(tx_valid), 0);
    put_words(10, 41, 6, 7);
    check(tx_valid == 1'b1, "R6", int'(tx_valid), 1);
    drain();

    // R4 four extra bytes with auto-CRC off
    cur_req = "R4";
    set_ctrl(1, 0);
    put_words(10, 77, 0, 7);
    check(tx_valid == 1'b0, "R4", int'(tx_valid), 0);
    put_words(10, 77, 7, 8);
    check(tx_valid == 1'b1, "R4", int'(tx_valid), 1);
    drain();

    // R5 fill level code 2 -> 68 bytes
    cur_req = "R5";
    set_ctrl(0, 1);
    set_thr(2);
    put_words(20, 90, 0, 16);
    check(tx_valid == 1'b0, "R5", int'(tx_valid), 0);
    put_words(20, 90, 16, 17);
    check(tx_valid == 1'b1, "R5", int'(tx_valid), 1);
    drain();

    // R13 stall hold, R12 writes during streaming ignored
    cur_req = "R13";
    set_thr(0);
    hold_ready = 1;
    put_words(20, 123, 0, 9);
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b1 && tx_last == 1'b0, "R13", int'({tx_valid, tx_last}), 2);
    check(tx_data == exp_q[0][7:0], "R13", int'(tx_data), int'(exp_q[0][7:0]));
    for (int i = 0; i < 4; i++) wr(3'd0, 32'hA5A5_0000 + 32'(i));
    repeat (2) @(negedge clk);
    check(tx_data == exp_q[0][7:0], "R13", int'(tx_data), int'(exp_q[0][7:0]));
    hold_ready = 0;
    drain();
    cur_req = "R12";
    set_thr(63);
    data_wr(word_of(50, 200, 0));
    treq();
    drain();

    // R2 oversize length rejected, R9 longest frame, R4 cap at 2048
    cur_req = "R2";
    set_ctrl(0, 0);
    set_thr(0);
    data_wr(32'h0000_07F1);
    repeat (2) @(negedge clk);
    check(err_seen == exp_err, "R2", err_seen, exp_err);
    cur_req = "R9";
    put_words(2032, 17, 0, 511);
    check(tx_valid == 1'b0, "R4", int'(tx_valid), 0);
    put_words(2032, 17, 511, 512);
    check(tx_valid == 1'b1, "R4", int'(tx_valid), 1);
    check(exp_q.size() == 2046, "R9", exp_q.size(), 2046);
    drain();

    // R3 writes past a full buffer dropped
    cur_req = "R3";
    set_ctrl(0, 1);
    set_thr(63);
    put_words(40, 55, 0, 512);
    for (int i = 0; i < 8; i++) data_wr(32'hDEAD_BEEF);
    treq();
    drain();

    // R11 acknowledge empties a half-written frame
    cur_req = "R11";
    set_thr(0);
    put_words(20, 9, 0, 3);
    wr(3'd4, 32'd1);
    m_fill = 0;
    put_words(24, 61, 0, 10);
    check(tx_valid == 1'b1, "R11", int'(tx_valid), 1);
    drain();

    check(empty_seen == exp_empty, "R10", empty_seen, exp_empty);
    check(err_seen == exp_err, "R2", err_seen, exp_err);
    report();
  end
endmodule